// File: doc/BRIEF.md
# Descriptor Ring Walker

This block runs a circular chain of transfer records held in memory. Each record describes one copy job (source address, destination address, length in beats) and carries the address of the record that follows it. The last record links back to the first, so the records form a ring. The walker is started with the address of the first record. It then repeats four steps for each record: read the record, issue its beats, wait for the transfer engine to report completion, and follow the link.

While a record executes, the walker produces one source and one destination beat address per cycle. Both addresses start at the record's values and advance by one word per beat. When an address equals the configured wrap point, the next address becomes the wrap target. A pass ends when a record's link equals the starting address. At that point the walker raises a one-cycle completion pulse and either stops or, in continuous mode, starts the ring again. An abort input sends it back to idle at any time.

Top module: `desc_ring_walker`

## Requirements
- R1: After reset, and whenever idle, `busy`, `mem_req`, `beat_valid`, `eng_go` and `list_done` are low.
- R2: A start pulse while idle latches `head_ptr` and reads the record at that address as four words at byte offsets 0, 4, 8 and 12. Each word is a single `mem_req`, and the next word is not requested until the previous word's `mem_rvalid` has arrived.
- R3: Record word 0 is the source address, word 1 the destination address, word 2 the length in beats and word 3 the link. `eng_go` pulses with `eng_len` equal to word 2. Then `beat_valid` is high for exactly that many consecutive cycles. The beat addresses start at words 0 and 1 and each advances by 4 per beat.
- R4: Before each advance, the current beat address is compared for equality with `wrap_at`. On a match, the next address is `wrap_to` instead of the current address plus 4. Source and destination lanes wrap independently.
- R5: The next record is requested only after `eng_done` has been seen for the current record, and it is read at that record's link address. No memory request overlaps a beat.
- R6: A record of length 0 produces no beats. The walker goes straight to waiting for `eng_done`.
- R7: When a record whose link equals the latched start address completes, `list_done` pulses for one cycle. With `continuous` low, the walker then returns to idle.
- R8: With `continuous` high, the walker re-reads the ring from the start address after each `list_done`, and each pass repeats the same beat addresses.
- R9: `abort` returns the walker to idle on the next cycle from any state. A memory response that was in flight at the abort is discarded and never taken as part of a later record.
- R10: `start` and changes to `head_ptr` while busy have no effect on the walk in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin walking at `head_ptr` (idle only) |
| abort | input | 1 | Return to idle next cycle |
| continuous | input | 1 | Keep looping the ring after each pass |
| head_ptr | input | AW | Address of the first record |
| wrap_at | input | AW | Beat address at which the lanes wrap |
| wrap_to | input | AW | Beat address that follows `wrap_at` |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | AW | Read byte address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| eng_go | output | 1 | Record loaded, engine may start |
| eng_len | output | LEN_W | Beat count of the loaded record |
| eng_done | input | 1 | Engine finished the current record |
| beat_valid | output | 1 | Beat address valid this cycle |
| beat_src | output | AW | Source beat address |
| beat_dst | output | AW | Destination beat address |
| list_done | output | 1 | One pass of the ring completed |
| busy | output | 1 | Walker not idle |

## Verification
The assertions assume that memory returns `mem_rvalid` no earlier than the cycle after its `mem_req` and only for a request that was issued. They also assume that `wrap_at` and `wrap_to` hold steady while beats are issued, and that `eng_done` arrives only while the walker waits for it. The bench's memory model answers every request after a fixed two-cycle delay. Its engine stub counts the beats it receives against `eng_len` and pulses `eng_done` only after the last beat. The wrap registers are changed only while the walker is idle.

// File: rtl/rwk_pkg.sv
package rwk_pkg;

    localparam int DATA_W        = 32;
    localparam int REC_WORDS     = 4;
    localparam int REC_IDX_W     = $clog2(REC_WORDS);

    // Word order inside one record in memory
    localparam int W_SRC  = 0;
    localparam int W_DST  = 1;
    localparam int W_LEN  = 2;
    localparam int W_LINK = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_EXEC,
        ST_WAIT,
        ST_ADV
    } walk_st_e;

    typedef struct packed {
        logic [DATA_W-1:0] src;
        logic [DATA_W-1:0] dst;
        logic [DATA_W-1:0] len;
        logic [DATA_W-1:0] link;
    } rec_t;

endpackage

// File: rtl/rwk_rec_loader.sv
module rwk_rec_loader
    import rwk_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [AW-1:0]     base,
    input  logic              flush,
    output logic              mem_req,
    output logic [AW-1:0]     mem_addr,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done,
    output rec_t              rec
);

    localparam int WORD_BYTES = DATA_W / 8;

    typedef struct packed {
        logic                              active;
        logic                              pend;
        logic                              stale;
        logic                              done;
        logic [REC_IDX_W-1:0]              idx;
        logic [AW-1:0]                     base;
        logic [REC_WORDS-1:0][DATA_W-1:0]  words;
    } ld_regs_t;

    ld_regs_t r_q, r_d;
    logic     issue;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        issue    = r_q.active && !r_q.pend && !flush;

        if (mem_rvalid && r_q.pend) begin
            r_d.pend = 1'b0;
            if (r_q.stale) begin
                r_d.stale = 1'b0;
            end else if (r_q.active) begin
                r_d.words[r_q.idx] = mem_rdata;
                if (r_q.idx == REC_IDX_W'(REC_WORDS - 1)) begin
                    r_d.active = 1'b0;
                    r_d.done   = 1'b1;
                end else begin
                    r_d.idx = r_q.idx + 1'b1;
                end
            end
        end

        if (issue) begin
            r_d.pend = 1'b1;
        end

        if (flush) begin
            r_d.active = 1'b0;
            r_d.done   = 1'b0;
            r_d.stale  = r_d.pend;
        end else if (go) begin
            r_d.active = 1'b1;
            r_d.idx    = '0;
            r_d.base   = base;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_req  = issue;
    assign mem_addr = r_q.base + AW'(r_q.idx) * AW'(WORD_BYTES);
    assign done     = r_q.done;

    always_comb begin
        rec.src  = r_q.words[W_SRC];
        rec.dst  = r_q.words[W_DST];
        rec.len  = r_q.words[W_LEN];
        rec.link = r_q.words[W_LINK];
    end

endmodule

// File: rtl/rwk_wrap_ctr.sv
module rwk_wrap_ctr #(
    parameter int AW   = 32,
    parameter int STEP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step,
    input  logic [AW-1:0] wrap_at,
    input  logic [AW-1:0] wrap_to,
    output logic [AW-1:0] addr
);

    logic [AW-1:0] addr_q, addr_d;

    always_comb begin
        addr_d = addr_q;
        if (load) begin
            addr_d = load_val;
        end else if (step) begin
            if (addr_q == wrap_at) begin
                addr_d = wrap_to;
            end else begin
                addr_d = addr_q + AW'(STEP);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else begin
            addr_q <= addr_d;
        end
    end

    assign addr = addr_q;

endmodule

// File: rtl/desc_ring_walker.sv
module desc_ring_walker
    import rwk_pkg::*;
#(
    parameter int AW    = 32,
    parameter int LEN_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic              continuous,
    input  logic [AW-1:0]     head_ptr,
    input  logic [AW-1:0]     wrap_at,
    input  logic [AW-1:0]     wrap_to,
    output logic              mem_req,
    output logic [AW-1:0]     mem_addr,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              eng_go,
    output logic [LEN_W-1:0]  eng_len,
    input  logic              eng_done,
    output logic              beat_valid,
    output logic [AW-1:0]     beat_src,
    output logic [AW-1:0]     beat_dst,
    output logic              list_done,
    output logic              busy
);

    localparam int NUM_LANES  = 2;
    localparam int BEAT_BYTES = DATA_W / 8;

    typedef struct packed {
        walk_st_e          st;
        logic [AW-1:0]     head;
        logic [AW-1:0]     link;
        logic [LEN_W-1:0]  remain;
    } walk_t;

    walk_t         w_q, w_d;
    logic          ld_go;
    logic [AW-1:0] ld_base;
    logic          ld_done;
    rec_t          ld_rec;
    logic          ctr_load;
    logic          ctr_step;
    logic          go_c;
    logic          pass_c;
    logic [LEN_W-1:0] rec_len;

    logic [NUM_LANES-1:0][AW-1:0] lane_init;
    logic [NUM_LANES-1:0][AW-1:0] lane_addr;

    assign rec_len = ld_rec.len[LEN_W-1:0];

    always_comb begin
        w_d      = w_q;
        ld_go    = 1'b0;
        ctr_load = 1'b0;
        ctr_step = 1'b0;
        go_c     = 1'b0;
        pass_c   = 1'b0;

        unique case (w_q.st)
            ST_IDLE: begin
                if (start) begin
                    w_d.head = head_ptr;
                    ld_go    = 1'b1;
                    w_d.st   = ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (ld_done) begin
                    w_d.link   = ld_rec.link[AW-1:0];
                    w_d.remain = rec_len;
                    ctr_load   = 1'b1;
                    go_c       = 1'b1;
                    w_d.st     = (rec_len == '0) ? ST_WAIT : ST_EXEC;
                end
            end
            ST_EXEC: begin
                ctr_step   = 1'b1;
                w_d.remain = w_q.remain - LEN_W'(1);
                if (w_q.remain == LEN_W'(1)) begin
                    w_d.st = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (eng_done) begin
                    w_d.st = ST_ADV;
                end
            end
            ST_ADV: begin
                if (w_q.link == w_q.head) begin
                    pass_c = 1'b1;
                    if (continuous) begin
                        ld_go  = 1'b1;
                        w_d.st = ST_FETCH;
                    end else begin
                        w_d.st = ST_IDLE;
                    end
                end else begin
                    ld_go  = 1'b1;
                    w_d.st = ST_FETCH;
                end
            end
            default: begin
                w_d.st = ST_IDLE;
            end
        endcase

        if (abort) begin
            w_d.st = ST_IDLE;
            ld_go  = 1'b0;
            go_c   = 1'b0;
            pass_c = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q    <= '0;
            w_q.st <= ST_IDLE;
        end else begin
            w_q <= w_d;
        end
    end

    assign ld_base = (w_q.st == ST_IDLE) ? head_ptr : w_q.link;

    rwk_rec_loader #(.AW(AW)) loader_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (ld_go),
        .base       (ld_base),
        .flush      (abort),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .done       (ld_done),
        .rec        (ld_rec)
    );

    assign lane_init[0] = ld_rec.src[AW-1:0];
    assign lane_init[1] = ld_rec.dst[AW-1:0];

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        rwk_wrap_ctr #(.AW(AW), .STEP(BEAT_BYTES)) ctr_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (ctr_load),
            .load_val (lane_init[g]),
            .step     (ctr_step),
            .wrap_at  (wrap_at),
            .wrap_to  (wrap_to),
            .addr     (lane_addr[g])
        );
    end

    assign beat_valid = (w_q.st == ST_EXEC);
    assign beat_src   = lane_addr[0];
    assign beat_dst   = lane_addr[1];
    assign eng_go     = go_c;
    assign eng_len    = rec_len;
    assign list_done  = pass_c;
    assign busy       = (w_q.st != ST_IDLE);

endmodule

// File: rtl/desc_ring_walker_chk.sv
module desc_ring_walker_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          abort,
    input logic          continuous,
    input logic          mem_req,
    input logic          eng_go,
    input logic          beat_valid,
    input logic [AW-1:0] beat_src,
    input logic [AW-1:0] wrap_at,
    input logic [AW-1:0] wrap_to,
    input logic          list_done,
    input logic          busy
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!beat_valid && !mem_req && !eng_go && !list_done)); // R1

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req); // R2

    AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && beat_src != wrap_at) |=> (!beat_valid || beat_src == $past(beat_src) + AW'(4))); // R3

    AST_BEAT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && beat_src == wrap_at) |=> (!beat_valid || beat_src == wrap_to)); // R4

    AST_NO_REQ_IN_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |-> !mem_req); // R5

    AST_PASS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (list_done && !continuous && !abort) |=> !busy); // R7

    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !busy); // R9

endmodule

bind desc_ring_walker desc_ring_walker_chk #(.AW(AW)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .abort      (abort),
    .continuous (continuous),
    .mem_req    (mem_req),
    .eng_go     (eng_go),
    .beat_valid (beat_valid),
    .beat_src   (beat_src),
    .wrap_at    (wrap_at),
    .wrap_to    (wrap_to),
    .list_done  (list_done),
    .busy       (busy)
);

// File: tb/desc_ring_walker_tb_top.sv
`timescale 1ns/1ps
module desc_ring_walker_tb_top;

    localparam int AW    = 32;
    localparam int LEN_W = 32;
    localparam int LOGN  = 1024;

    typedef struct packed {
        logic [31:0] head;
        logic [31:0] nrec;
        logic [31:0] len;
        logic [31:0] src0;
        logic [31:0] wrap_at;
        logic [31:0] wrap_to;
    } vec_t;

    // head, records, beats per record, first source, wrap point, wrap target
    localparam vec_t VECS [4] = '{
        '{32'h00, 32'd1, 32'd3, 32'h1000, 32'hFFFF_FFF0, 32'h0},
        '{32'h40, 32'd3, 32'd4, 32'h2000, 32'h2008,      32'h3000},
        '{32'h80, 32'd2, 32'd0, 32'h5000, 32'hFFFF_FFF0, 32'h0},
        '{32'h20, 32'd2, 32'd5, 32'h4000, 32'h14104,     32'h50}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, abort = 1'b0, continuous = 1'b0;
    logic [AW-1:0] head_ptr = '0, wrap_at = '1, wrap_to = '0;
    logic mem_req, mem_rvalid = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_rdata = '0;
    logic eng_go, eng_done = 1'b0, beat_valid, list_done, busy;
    logic [LEN_W-1:0] eng_len;
    logic [AW-1:0] beat_src, beat_dst;

    always #10 clk = ~clk;

    desc_ring_walker #(.AW(AW), .LEN_W(LEN_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
        .continuous(continuous), .head_ptr(head_ptr), .wrap_at(wrap_at),
        .wrap_to(wrap_to), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .eng_go(eng_go),
        .eng_len(eng_len), .eng_done(eng_done), .beat_valid(beat_valid),
        .beat_src(beat_src), .beat_dst(beat_dst), .list_done(list_done),
        .busy(busy)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory model and logs
    logic [31:0] mem [64];
    int lat_cnt = 0;
    logic [AW-1:0] lat_addr = '0;
    logic [AW-1:0] req_log [LOGN];
    logic [AW-1:0] src_log [LOGN];
    logic [AW-1:0] dst_log [LOGN];
    int n_req = 0, n_beat = 0, n_done = 0, n_overlap = 0;
    int e_need = 0, e_cnt = 0, e_dly = 0;
    bit e_arm = 1'b0;

    always @(negedge clk) begin
        mem_rvalid = 1'b0;
        if (lat_cnt == 1) begin
            mem_rvalid = 1'b1;
            mem_rdata  = mem[lat_addr[7:2]];
        end
        if (lat_cnt > 0) lat_cnt--;
        if (mem_req) begin
            lat_cnt  = 2;
            lat_addr = mem_addr;
            if (n_req < LOGN) req_log[n_req] = mem_addr;
            n_req++;
            if (beat_valid || e_arm) n_overlap++;
        end
        if (beat_valid) begin
            if (n_beat < LOGN) begin
                src_log[n_beat] = beat_src;
                dst_log[n_beat] = beat_dst;
            end
            n_beat++;
        end
        if (list_done) n_done++;
        // engine stub
        eng_done = 1'b0;
        if (abort) begin
            e_arm = 1'b0;
        end else if (eng_go) begin
            e_need = int'(eng_len);
            e_cnt  = 0;
            e_dly  = 0;
            e_arm  = 1'b1;
        end else if (e_arm) begin
            if (beat_valid) e_cnt++;
            if (e_cnt == e_need && !beat_valid) begin
                e_dly++;
                if (e_dly == 2) begin
                    eng_done = 1'b1;
                    e_arm    = 1'b0;
                end
            end
        end
    end

    // expected model
    logic [AW-1:0] exp_src [LOGN];
    logic [AW-1:0] exp_dst [LOGN];
    logic [AW-1:0] exp_req [LOGN];
    int exp_nb = 0, exp_nr = 0;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] a, input logic [AW-1:0] wa, input logic [AW-1:0] wt);
        return (a == wa) ? wt : a + 32'd4;
    endfunction

    task automatic build_ring(input int v);
        logic [AW-1:0] base, s, d;
        exp_nb = 0;
        exp_nr = 0;
        for (int i = 0; i < int'(VECS[v].nrec); i++) begin
            base = VECS[v].head + 32'(i) * 32'h20;
            s = VECS[v].src0 + 32'(i) * 32'h100;
            d = s + 32'h10000;
            mem[base[7:2] + 0] = s;
            mem[base[7:2] + 1] = d;
            mem[base[7:2] + 2] = VECS[v].len;
            mem[base[7:2] + 3] = (i == int'(VECS[v].nrec) - 1) ? VECS[v].head : base + 32'h20;
            for (int k = 0; k < 4; k++) begin
                exp_req[exp_nr] = base + 32'(4 * k);
                exp_nr++;
            end
            for (int k = 0; k < int'(VECS[v].len); k++) begin
                exp_src[exp_nb] = s;
                exp_dst[exp_nb] = d;
                exp_nb++;
                s = nxt(s, VECS[v].wrap_at, VECS[v].wrap_to);
                d = nxt(d, VECS[v].wrap_at, VECS[v].wrap_to);
            end
        end
    endtask

    task automatic cmp_logs(input int b0, input int r0, input int ov0);
        chk(n_beat - b0 == exp_nb, "R3 R6 beat count", 32'(n_beat - b0), 32'(exp_nb));
        for (int k = 0; k < exp_nb; k++) begin
            chk(src_log[b0 + k] == exp_src[k], "R3 R4 source beat", src_log[b0 + k], exp_src[k]);
            chk(dst_log[b0 + k] == exp_dst[k], "R3 R4 destination beat", dst_log[b0 + k], exp_dst[k]);
        end
        chk(n_req - r0 == exp_nr, "R2 read count", 32'(n_req - r0), 32'(exp_nr));
        for (int k = 0; k < exp_nr; k++) begin
            chk(req_log[r0 + k] == exp_req[k], "R2 R5 read address", req_log[r0 + k], exp_req[k]);
        end
        chk(n_overlap == ov0, "R5 read during transfer", 32'(n_overlap), 32'(ov0));
    endtask

    task automatic run_vec(input int v, input bit poke);
        int b0, r0, d0, ov0;
        build_ring(v);
        wrap_at  = VECS[v].wrap_at;
        wrap_to  = VECS[v].wrap_to;
        head_ptr = VECS[v].head;
        continuous = 1'b0;
        @(negedge clk);
        b0 = n_beat; r0 = n_req; d0 = n_done; ov0 = n_overlap;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (5) @(negedge clk);
            start = 1'b1;
            head_ptr = 32'hC0;   // R10: must be ignored
            @(negedge clk);
            start = 1'b0;
            head_ptr = VECS[v].head;
        end
        while (busy) @(negedge clk);
        @(negedge clk);
        chk(n_done - d0 == 1, "R7 one pass pulse", 32'(n_done - d0), 32'd1);
        chk(!busy, "R7 idle after pass", 32'(busy), 32'd0);
        cmp_logs(b0, r0, ov0);
    endtask

    initial begin : wdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        int b0, r0, d0, ov0;
        for (int i = 0; i < 64; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy && !mem_req && !beat_valid && !list_done && !eng_go, "R1 in reset",
            {27'd0, busy, mem_req, beat_valid, list_done, eng_go}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy && !mem_req && !beat_valid && !list_done && !eng_go, "R1 after reset",
            {27'd0, busy, mem_req, beat_valid, list_done, eng_go}, 32'd0);

        // table walk
        for (int v = 0; v < 4; v++) begin
            run_vec(v, 1'b0);
        end

        // R10 start while busy
        run_vec(1, 1'b1);

        // R8 continuous looping, then R9 abort
        build_ring(1);
        wrap_at = VECS[1].wrap_at;
        wrap_to = VECS[1].wrap_to;
        head_ptr = VECS[1].head;
        continuous = 1'b1;
        @(negedge clk);
        b0 = n_beat; r0 = n_req; d0 = n_done;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        do @(posedge clk); while (n_done < d0 + 2);
        chk(n_beat - b0 == 2 * exp_nb, "R8 beats over two passes", 32'(n_beat - b0), 32'(2 * exp_nb));
        for (int k = 0; k < exp_nb; k++) begin
            chk(src_log[b0 + exp_nb + k] == exp_src[k], "R8 second pass source", src_log[b0 + exp_nb + k], exp_src[k]);
        end
        chk(req_log[r0 + exp_nr] == VECS[1].head, "R8 restart at head", req_log[r0 + exp_nr], VECS[1].head);
        @(negedge clk);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        continuous = 1'b0;
        chk(!busy, "R9 idle after abort", 32'(busy), 32'd0);
        b0 = n_beat; r0 = n_req;
        repeat (10) @(negedge clk);
        chk(n_beat == b0 && n_req == r0 && !busy, "R9 quiet after abort", 32'(n_beat - b0 + n_req - r0), 32'd0);

        // R9 stale response discarded
        build_ring(1);
        build_ring(0);
        wrap_at = VECS[0].wrap_at;
        wrap_to = VECS[0].wrap_to;
        head_ptr = VECS[1].head;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!mem_req) @(negedge clk);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        chk(!busy, "R9 abort during fetch", 32'(busy), 32'd0);
        head_ptr = VECS[0].head;
        b0 = n_beat; r0 = n_req; d0 = n_done; ov0 = n_overlap;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (busy) @(negedge clk);
        @(negedge clk);
        chk(n_done - d0 == 1, "R9 pass after restart", 32'(n_done - d0), 32'd1);
        cmp_logs(b0, r0, ov0);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule